// File: doc/BRIEF.md
# Counted Configuration Clock Pulse Generator

This block produces a software-chosen number of clock pulses on a single output pin. Software writes a burst length into a count register. The block then emits that many pulses, each derived from a dedicated configuration clock. When the last pulse has gone out, the block raises a sticky done flag in a status register. Software polls that flag and clears it by writing 1 to it.

The register side runs on its own clock, which is asynchronous to the configuration clock. The start request crosses into the configuration domain as a toggle that is resynchronized there. The burst length is taken from a register-side holding register, which stays unchanged while the request is outstanding. The end of the burst crosses back as a second toggle, which is resynchronized and edge-detected.

A burst is accepted only when the block is idle and done is clear. Any other count write is dropped, and a sticky error flag records it. Reads are registered and return the addressed register one register-clock cycle later.

Top module: `cfg_pulse_gen`

## Requirements
- R1: Writing a value N greater than 0 to the count register (address 0), while the block is idle and done is clear, produces exactly N pulses on `pulse_out`.
- R2: Each pulse is high for exactly one `cfg_clk` cycle and is followed by at least one low cycle. `pulse_out` stays low whenever no burst is running.
- R3: After the last pulse of an accepted burst, the done flag (status register at address 1, bit 0) reads 1. It stays 1 until software writes a 1 to status bit 0.
- R4: A status write with bit 0 equal to 0 leaves the done flag unchanged.
- R5: Writing 0 to the count register, while the block is idle and done is clear, sets done without emitting any pulse.
- R6: A count write made while a burst is running or while done is set is ignored, so it produces no pulses. It sets the error flag (status bit 2).
- R7: The error flag is sticky and is cleared only by a status write with bit 2 equal to 1.
- R8: The busy flag (status bit 1) reads 1 from an accepted nonzero count write until the burst completes. It reads 0 whenever done reads 1.
- R9: After reset, status reads 0 and `pulse_out` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| reg_clk | input | 1 | Register interface clock |
| reg_rst | input | 1 | Synchronous active-high reset, register domain |
| reg_wr | input | 1 | Write strobe |
| reg_addr | input | 1 | Register select: 0 count, 1 status |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data for `reg_addr` |
| cfg_clk | input | 1 | Configuration clock |
| cfg_rst | input | 1 | Synchronous active-high reset, configuration domain |
| pulse_out | output | 1 | Counted pulse output |

## Verification
Read data is due on the register-clock edge after the address is set, so the bench changes the address on a falling edge and samples on the following falling edge. Done and busy follow a write only after two synchronizers and the pulse train itself have run, which takes an unfixed number of cycles. The bench therefore polls status under a bounded timeout rather than at a fixed cycle. Pulses are counted on every `cfg_clk` rising edge by a monitor that also flags two consecutive high samples. For ignored writes, the bench waits longer than any crossing latency and then compares the pulse count and status against their earlier values.

// File: rtl/cfg_pulse_pkg.sv
package cfg_pulse_pkg;
  localparam int unsigned ST_DONE = 0;
  localparam int unsigned ST_BUSY = 1;
  localparam int unsigned ST_ERR  = 2;
  localparam logic        A_COUNT  = 1'b0;
  localparam logic        A_STATUS = 1'b1;
endpackage

// File: rtl/cpg_sync.sv
module cpg_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk) begin
    if (rst) chain_q <= '0;
    else     chain_q <= {chain_q[STAGES-2:0], d};
  end

  assign q = chain_q[STAGES-1];
endmodule

// File: rtl/cpg_engine.sv
module cpg_engine #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [CNT_W-1:0] count_in,
  output logic             pulse,
  output logic             done_tog
);
  logic [CNT_W-1:0] left_q;
  logic             phase_q;
  logic             pulse_q;
  logic             tog_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      left_q  <= '0;
      phase_q <= 1'b0;
      pulse_q <= 1'b0;
      tog_q   <= 1'b0;
    end else if (start) begin
      left_q  <= count_in;
      phase_q <= 1'b0;
      pulse_q <= 1'b0;
    end else if (left_q != '0) begin
      if (!phase_q) begin
        pulse_q <= 1'b1;
        phase_q <= 1'b1;
      end else begin
        pulse_q <= 1'b0;
        phase_q <= 1'b0;
        left_q  <= left_q - 1'b1;
        if (left_q == CNT_W'(1)) tog_q <= ~tog_q;
      end
    end
  end

  assign pulse    = pulse_q;
  assign done_tog = tog_q;

  p_pulse_one_cycle_r2: assert property (@(posedge clk) disable iff (rst)
    pulse_q |=> !pulse_q);
  p_idle_low_r2: assert property (@(posedge clk) disable iff (rst)
    (left_q == '0) |=> !pulse_q);
  p_done_after_last_r3: assert property (@(posedge clk) disable iff (rst)
    (tog_q != $past(tog_q)) |-> (left_q == '0));
endmodule

// File: rtl/cpg_regs.sv
module cpg_regs #(
  parameter int unsigned CNT_W  = 32,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  logic              addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic              done_evt,
  output logic              req_tog,
  output logic [CNT_W-1:0]  count_hold
);
  import cfg_pulse_pkg::*;

  logic             done_q, busy_q, err_q, tog_q;
  logic [CNT_W-1:0] cnt_q;
  logic [DATA_W-1:0] rd_q;
  logic             wr_cnt, wr_st, accept;

  assign wr_cnt = wr && (addr == A_COUNT);
  assign wr_st  = wr && (addr == A_STATUS);
  assign accept = wr_cnt && !busy_q && !done_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      done_q <= 1'b0;
      busy_q <= 1'b0;
      err_q  <= 1'b0;
      tog_q  <= 1'b0;
      cnt_q  <= '0;
    end else begin
      if (accept) begin
        cnt_q <= wdata[CNT_W-1:0];
        if (wdata[CNT_W-1:0] == '0) begin
          done_q <= 1'b1;
        end else begin
          busy_q <= 1'b1;
          tog_q  <= ~tog_q;
        end
      end else if (wr_cnt) begin
        err_q <= 1'b1;
      end
      if (done_evt) begin
        busy_q <= 1'b0;
        done_q <= 1'b1;
      end else if (wr_st && wdata[ST_DONE]) begin
        done_q <= 1'b0;
      end
      if (wr_st && wdata[ST_ERR]) err_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rd_q <= '0;
    else if (addr == A_COUNT) rd_q <= DATA_W'(cnt_q);
    else begin
      rd_q          <= '0;
      rd_q[ST_DONE] <= done_q;
      rd_q[ST_BUSY] <= busy_q;
      rd_q[ST_ERR]  <= err_q;
    end
  end

  assign rdata      = rd_q;
  assign req_tog    = tog_q;
  assign count_hold = cnt_q;

  p_done_sticky_r3: assert property (@(posedge clk) disable iff (rst)
    (done_q && !(wr_st && wdata[ST_DONE])) |=> done_q);
  p_reject_sets_err_r6: assert property (@(posedge clk) disable iff (rst)
    (wr_cnt && (busy_q || done_q)) |=> err_q);
  p_no_start_when_blocked_r6: assert property (@(posedge clk) disable iff (rst)
    (busy_q || done_q) |=> $stable(tog_q));
  p_hold_stable_r1: assert property (@(posedge clk) disable iff (rst)
    busy_q && $past(busy_q) |-> $stable(cnt_q));
  p_err_sticky_r7: assert property (@(posedge clk) disable iff (rst)
    (err_q && !(wr_st && wdata[ST_ERR])) |=> err_q);
  p_busy_done_excl_r8: assert property (@(posedge clk) disable iff (rst)
    !(busy_q && done_q));
endmodule

// File: rtl/cfg_pulse_gen.sv
module cfg_pulse_gen #(
  parameter int unsigned CNT_W     = 32,
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned SYNC_STGS = 2
) (
  input  logic              reg_clk,
  input  logic              reg_rst,
  input  logic              reg_wr,
  input  logic              reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              cfg_clk,
  input  logic              cfg_rst,
  output logic              pulse_out
);
  logic             req_tog, req_s, req_d, start;
  logic [CNT_W-1:0] count_hold;
  logic             done_tog, done_s, done_d, done_evt;

  cpg_regs #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_regs (
    .clk(reg_clk), .rst(reg_rst), .wr(reg_wr), .addr(reg_addr),
    .wdata(reg_wdata), .rdata(reg_rdata), .done_evt(done_evt),
    .req_tog(req_tog), .count_hold(count_hold)
  );

  cpg_sync #(.STAGES(SYNC_STGS)) u_req_sync (
    .clk(cfg_clk), .rst(cfg_rst), .d(req_tog), .q(req_s)
  );

  always_ff @(posedge cfg_clk) begin
    if (cfg_rst) req_d <= 1'b0;
    else         req_d <= req_s;
  end
  assign start = req_s ^ req_d;

  cpg_engine #(.CNT_W(CNT_W)) u_engine (
    .clk(cfg_clk), .rst(cfg_rst), .start(start), .count_in(count_hold),
    .pulse(pulse_out), .done_tog(done_tog)
  );

  cpg_sync #(.STAGES(SYNC_STGS)) u_done_sync (
    .clk(reg_clk), .rst(reg_rst), .d(done_tog), .q(done_s)
  );

  always_ff @(posedge reg_clk) begin
    if (reg_rst) done_d <= 1'b0;
    else         done_d <= done_s;
  end
  assign done_evt = done_s ^ done_d;
endmodule

// File: tb/test_cfg_pulse_gen.sv
`timescale 1ns/1ps
module test_cfg_pulse_gen;
  logic        reg_clk = 0, cfg_clk = 0, reg_rst = 1, cfg_rst = 1;
  logic        reg_wr = 0, reg_addr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic        pulse_out;
  int total = 0, bad = 0;
  int pcount = 0, dbl = 0;
  logic prev_p = 0;
  logic [31:0] st;

  always #4 reg_clk = ~reg_clk;
  always #3.3 cfg_clk = ~cfg_clk;

  cfg_pulse_gen i_cfg_pulse_gen (
    .reg_clk(reg_clk), .reg_rst(reg_rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cfg_clk(cfg_clk),
    .cfg_rst(cfg_rst), .pulse_out(pulse_out)
  );

  always @(posedge cfg_clk) begin
    #0.5;
    if (!cfg_rst) begin
      if (pulse_out) pcount++;
      if (pulse_out && prev_p) dbl++;
      prev_p = pulse_out;
    end
  end

  function automatic logic [31:0] exp_status(logic d, logic b, logic e);
    return {29'b0, e, b, d};
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic a, logic [31:0] d);
    @(negedge reg_clk);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge reg_clk);
    reg_wr = 0; reg_wdata = 0;
  endtask

  task automatic rd(logic a, output logic [31:0] d);
    @(negedge reg_clk);
    reg_addr = a;
    @(negedge reg_clk);
    d = reg_rdata;
  endtask

  task automatic wait_done(output logic [31:0] s);
    s = 0;
    for (int i = 0; i < 2000; i++) begin
      rd(1'b1, s);
      if (s[0]) break;
    end
  endtask

  task automatic settle();
    repeat (40) @(negedge reg_clk);
  endtask

  task automatic burst(int n, string req);
    int base;
    logic [31:0] s;
    base = pcount;
    wr(1'b0, n);
    wait_done(s);
    settle();
    check(req, pcount - base, n);
    check("R3", s, exp_status(1, 0, 0));
    wr(1'b1, 32'h1);
    rd(1'b1, s);
    check("R3", s, exp_status(0, 0, 0));
  endtask

  initial begin
    logic [31:0] s;
    int base;
    void'($urandom(1234));
    repeat (5) @(negedge reg_clk);
    reg_rst = 0; cfg_rst = 0;
    rd(1'b1, s);
    check("R9", s, 0);
    check("R9", {31'b0, pulse_out}, 0);

    burst(1, "R1");
    burst(7, "R1");

    base = pcount;
    wr(1'b0, 0);
    rd(1'b1, s);
    check("R5", s, exp_status(1, 0, 0));
    settle();
    check("R5", pcount - base, 0);
    wr(1'b1, 32'h0);
    rd(1'b1, s);
    check("R4", s, exp_status(1, 0, 0));
    base = pcount;
    wr(1'b0, 9);
    settle();
    check("R6", pcount - base, 0);
    rd(1'b1, s);
    check("R6", s, exp_status(1, 0, 1));
    wr(1'b1, 32'h1);
    rd(1'b1, s);
    check("R7", s, exp_status(0, 0, 1));
    wr(1'b1, 32'h4);
    rd(1'b1, s);
    check("R7", s, exp_status(0, 0, 0));

    base = pcount;
    wr(1'b0, 40);
    rd(1'b1, s);
    check("R8", s, exp_status(0, 1, 0));
    wr(1'b0, 5);
    rd(1'b1, s);
    check("R6", s, exp_status(0, 1, 1));
    rd(1'b0, s);
    check("R6", s, 40);
    wait_done(s);
    settle();
    check("R1", pcount - base, 40);
    check("R8", s, exp_status(1, 0, 1));
    wr(1'b1, 32'h5);
    rd(1'b1, s);
    check("R7", s, 0);

    for (int k = 0; k < 12; k++) burst(1 + ($urandom % 30), "R1");

    base = pcount;
    settle();
    check("R2", pcount - base, 0);
    check("R2", dbl, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #1200000;
    total++; bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule